// File: doc/BRIEF.md
# Position Word Bus Port

This block sits between a live angular position counter and a host bus. On every clock it copies the counter's value into an output register. When the counter is part-way through an update, it skips that cycle. The host pulls an active-low hold line to freeze that register so that a multi-access read sees a consistent word. A settle flag rises a fixed number of clocks after the freeze has taken effect. Only then should the host trust the pins.

The held word is natural binary. A two-bit resolution code chooses how many low bits of the count are kept, and the bits above that width read as zero. An active-low output enable turns on the data pins, which are modelled as per-pin data and per-pin enable signals. A wide host takes the full word on all pins. A narrow host reads through the lowest byte lane and picks the upper or lower half with a byte-select input.

Top module: `posn_bus_port`

## Requirements
- R1: While reset is low, and in the first cycle after it, the held word is zero, all pin enables are low, all pin data reads zero while output enable is inactive, and the settle flag is low.
- R2: With hold high and busy low at a clock edge, the held word after that edge equals the live count sampled at that edge, masked to the selected resolution.
- R3: With busy high at a clock edge, the held word does not change at that edge.
- R4: The first edge with hold low and busy low captures the live count. After that, the word stays fixed while hold stays low, whatever the count and busy do.
- R5: If hold falls while busy is high, the freeze is postponed until the first edge with busy low, and the count at that edge is the value held.
- R6: The settle flag is low while tracking. It rises exactly SETTLE_CYC edges after the capture edge and stays high while hold stays low.
- R7: With output enable high, every pin enable is 0 and every data pin reads 0.
- R8: In narrow mode (wide_mode = 0) with output enable low, pins 7..0 carry word bits 15..8 when byte select is 1 and bits 7..0 when it is 0. Enables 7..0 are 1.
- R9: In narrow mode, pins 15..8 have enable 0 and data 0 whatever the byte select.
- R10: In wide mode (wide_mode = 1) with output enable low, all 16 pins carry the word with enable 1, and byte select has no effect.
- R11: Resolution code 00, 01, 10 and 11 keeps the low 10, 12, 14 and 16 bits of the count respectively, and the higher bits of the word are 0.
- R12: The first edge with hold high again resumes tracking (as in R2), and the settle flag is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_in | input | 16 | Live position count |
| cnt_busy | input | 1 | High while the counter is updating |
| res_sel | input | 2 | Resolution code (00=10, 01=12, 10=14, 11=16 bits) |
| hold_n | input | 1 | Active-low freeze of the held word |
| oe_n | input | 1 | Active-low enable for the data pins |
| wide_mode | input | 1 | 1 = 16-bit host, 0 = 8-bit host |
| hi_byte_sel | input | 1 | Narrow mode: 1 = upper byte, 0 = lower byte |
| bus_d | output | 16 | Per-pin data value |
| bus_oe | output | 16 | Per-pin drive enable (0 = high impedance) |
| data_ok | output | 1 | Settle flag, high once a frozen word is stable |

## Verification
The bench requests a freeze while busy is high. A design that froze at once would keep a stale count, and one that forgot the pending request would go on tracking. It times the settle flag edge by edge against the capture edge, which exposes an off-by-one counter or a flag that stays high after release. A sweep of every combination of output enable, bus width and byte select, with several word values, would catch crossed byte halves and upper pins that drive in narrow mode. A sweep of every resolution code with all-ones and sparse counts would catch a wrong mask width.

// File: rtl/posn_port_pkg.sv
`timescale 1ns/1ps
// posn_port_pkg: shared types and helpers for the position bus port.
// Assumes the full word is at least 10 bits wide.
package posn_port_pkg;

    // Resolution code; the encoding matches the res_sel pins.
    typedef enum logic [1:0] {
        RES_10 = 2'b00,
        RES_12 = 2'b01,
        RES_14 = 2'b10,
        RES_16 = 2'b11
    } res_sel_e;

    // Number of kept low bits: the full width minus six, plus two per code step.
    function automatic int unsigned res_bits(input res_sel_e code, input int unsigned full_w);
        return full_w - 32'd6 + 32'd2 * 32'(code);
    endfunction

endpackage

// File: rtl/posn_capture.sv
`timescale 1ns/1ps
// posn_capture: holds the output word. It follows the live count on every
// non-busy cycle. A hold request freezes it on the first non-busy cycle, so a
// freeze never lands in the middle of a counter update.
// Assumes cnt_in and cnt_busy are synchronous to clk.
module posn_capture
    import posn_port_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cnt_in,
    input  logic              cnt_busy,
    input  logic [1:0]        res_sel,
    input  logic              hold_n,
    output logic [WORD_W-1:0] word_q,
    output logic              frozen_q
);

    logic [WORD_W-1:0] keep;
    logic [WORD_W-1:0] masked;
    logic              load;
    logic              frozen_d;
    int unsigned       keep_w;

    // Number of bits kept at the current resolution.
    always_comb keep_w = res_bits(res_sel_e'(res_sel), WORD_W);

    // One mask bit per word bit: set below the kept width.
    for (genvar g = 0; g < WORD_W; g++) begin : g_keep
        assign keep[g] = (32'(g) < keep_w);
    end

    // Count trimmed to the selected resolution.
    always_comb masked = cnt_in & keep;

    // Load when not busy, and either tracking or a freeze is still pending.
    always_comb load = !cnt_busy && (hold_n || !frozen_q);

    // The freeze takes hold at the first non-busy edge with hold low and is kept while hold stays low.
    always_comb frozen_d = !hold_n && (frozen_q || !cnt_busy);

    // Output word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= masked;
        end
    end

    // Freeze state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen_q <= 1'b0;
        end else begin
            frozen_q <= frozen_d;
        end
    end

endmodule

// File: rtl/posn_settle_timer.sv
`timescale 1ns/1ps
// posn_settle_timer: counts clocks after a freeze has taken effect and
// raises ready once SETTLE_CYC have elapsed. It restarts whenever the word is
// not frozen or hold is released.
// Assumes frozen follows the capture register's state.
module posn_settle_timer #(
    parameter int SETTLE_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frozen,
    input  logic hold_n,
    output logic ready
);

    localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    // Elapsed-cycle counter, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!frozen || hold_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Ready once the frozen word has had its full settle time.
    always_comb ready = frozen && (cnt_q == LIMIT);

endmodule

// File: rtl/posn_lane_mux.sv
`timescale 1ns/1ps
// posn_lane_mux: maps the held word onto the data pins. In wide mode every
// lane carries its own byte. In narrow mode only lane 0 drives, and it carries
// the top or bottom byte.
// Assumes WORD_W is a whole multiple of BYTE_W.
module posn_lane_mux #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [WORD_W-1:0] word,
    input  logic              drive,
    input  logic              wide,
    input  logic              hi_sel,
    output logic [WORD_W-1:0] pin_d,
    output logic [WORD_W-1:0] pin_oe
);

    localparam int LANES = WORD_W / BYTE_W;
    localparam int TOP   = LANES - 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_base
            logic [BYTE_W-1:0] pick;
            // Narrow-mode byte choice for the shared lane.
            always_comb pick = hi_sel ? word[TOP*BYTE_W +: BYTE_W] : word[0 +: BYTE_W];
            // Base lane: own byte when wide, picked byte when narrow.
            always_comb begin
                pin_d[0 +: BYTE_W]  = !drive ? '0 : (wide ? word[0 +: BYTE_W] : pick);
                pin_oe[0 +: BYTE_W] = {BYTE_W{drive}};
            end
        end else begin : g_upper
            // Upper lanes drive only for a wide host.
            always_comb begin
                pin_d[l*BYTE_W +: BYTE_W]  = (drive && wide) ? word[l*BYTE_W +: BYTE_W] : '0;
                pin_oe[l*BYTE_W +: BYTE_W] = {BYTE_W{drive && wide}};
            end
        end
    end

endmodule

// File: rtl/posn_bus_port.sv
`timescale 1ns/1ps
// posn_bus_port: top of the position output port. It ties together the
// capture register, the settle timer and the pin lane multiplexer.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module posn_bus_port #(
    parameter int WORD_W     = 16,
    parameter int BYTE_W     = 8,
    parameter int SETTLE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cnt_in,
    input  logic              cnt_busy,
    input  logic [1:0]        res_sel,
    input  logic              hold_n,
    input  logic              oe_n,
    input  logic              wide_mode,
    input  logic              hi_byte_sel,
    output logic [WORD_W-1:0] bus_d,
    output logic [WORD_W-1:0] bus_oe,
    output logic              data_ok
);

    logic [WORD_W-1:0] word_q;
    logic              frozen_q;

    // Held word and freeze state.
    posn_capture #(.WORD_W(WORD_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_in   (cnt_in),
        .cnt_busy (cnt_busy),
        .res_sel  (res_sel),
        .hold_n   (hold_n),
        .word_q   (word_q),
        .frozen_q (frozen_q)
    );

    // Settle flag after a freeze.
    posn_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .frozen (frozen_q),
        .hold_n (hold_n),
        .ready  (data_ok)
    );

    // Pin drive and byte lane selection.
    posn_lane_mux #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lanes (
        .word   (word_q),
        .drive  (!oe_n),
        .wide   (wide_mode),
        .hi_sel (hi_byte_sel),
        .pin_d  (bus_d),
        .pin_oe (bus_oe)
    );

endmodule

// File: rtl/posn_bus_port_chk.sv
`timescale 1ns/1ps
// posn_bus_port_chk: temporal checks on the position port, bound to the top.
module posn_bus_port_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] cnt_in,
    input logic              cnt_busy,
    input logic [1:0]        res_sel,
    input logic              hold_n,
    input logic              oe_n,
    input logic              wide_mode,
    input logic [WORD_W-1:0] bus_oe,
    input logic              data_ok,
    input logic [WORD_W-1:0] word_q,
    input logic              frozen_q
);

    // R2
    full_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_n && !cnt_busy && res_sel == 2'b11) |=> (word_q == $past(cnt_in)));

    // R3
    busy_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_busy |=> $stable(word_q));

    // R4
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !hold_n) |=> $stable(word_q));

    // R6
    ok_needs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ok |-> frozen_q);

    // R7
    pins_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (bus_oe == '0));

    // R9
    narrow_upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (bus_oe[WORD_W-1:8] == '0));

    // R12
    release_clears_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_n |=> !data_ok);

endmodule

bind posn_bus_port posn_bus_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_in    (cnt_in),
    .cnt_busy  (cnt_busy),
    .res_sel   (res_sel),
    .hold_n    (hold_n),
    .oe_n      (oe_n),
    .wide_mode (wide_mode),
    .bus_oe    (bus_oe),
    .data_ok   (data_ok),
    .word_q    (word_q),
    .frozen_q  (frozen_q)
);

// File: tb/test_posn_bus_port.sv
`timescale 1ns/1ps
module test_posn_bus_port;

    localparam int S = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_in;
    logic        cnt_busy;
    logic [1:0]  res_sel;
    logic        hold_n;
    logic        oe_n;
    logic        wide_mode;
    logic        hi_byte_sel;
    logic [15:0] bus_d;
    logic [15:0] bus_oe;
    logic        data_ok;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    posn_bus_port #(.WORD_W(16), .BYTE_W(8), .SETTLE_CYC(S)) i_posn_bus_port (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .cnt_busy(cnt_busy),
        .res_sel(res_sel), .hold_n(hold_n), .oe_n(oe_n), .wide_mode(wide_mode),
        .hi_byte_sel(hi_byte_sel), .bus_d(bus_d), .bus_oe(bus_oe), .data_ok(data_ok)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_of(input int r);
        return 16'((32'd1 << (10 + 2 * r)) - 1);
    endfunction

    // Held word as seen through a wide, enabled bus.
    task automatic read_word(output logic [15:0] w);
        oe_n = 1'b0; wide_mode = 1'b1;
        #1;
        w = bus_d;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [15:0] pats [6];
        pats[0] = 16'hFFFF; pats[1] = 16'hA5C3; pats[2] = 16'h0001;
        pats[3] = 16'h8000; pats[4] = 16'h3FF0; pats[5] = 16'h5A5A;

        rst_n = 1'b0; cnt_in = 16'hBEEF; cnt_busy = 1'b0; res_sel = 2'b11;
        hold_n = 1'b1; oe_n = 1'b1; wide_mode = 1'b1; hi_byte_sel = 1'b0;
        tick(); tick(); tick();
        // R1: reset state
        chk("R1 oe", 32'(bus_oe), 32'h0);
        chk("R1 data", 32'(bus_d), 32'h0);
        chk("R1 ok", 32'(data_ok), 32'h0);
        read_word(w);
        chk("R1 word", 32'(w), 32'h0);
        rst_n = 1'b1;

        // R2, R11: tracking across every resolution code and several counts
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 6; p++) begin
                res_sel = 2'(r); cnt_in = pats[p];
                tick();
                read_word(w);
                chk($sformatf("R11 R2 res%0d", r), 32'(w), 32'(pats[p] & mask_of(r)));
            end
        end
        res_sel = 2'b11;

        // R3: busy blocks updates
        cnt_in = 16'h1234; tick();
        cnt_busy = 1'b1; cnt_in = 16'h5678; tick();
        read_word(w); chk("R3 busy hold", 32'(w), 32'h1234);
        cnt_in = 16'h9999; tick();
        read_word(w); chk("R3 busy hold2", 32'(w), 32'h1234);
        cnt_busy = 1'b0; tick();
        read_word(w); chk("R2 after busy", 32'(w), 32'h9999);

        // R4, R6: freeze and settle timing
        cnt_in = 16'hC0DE; hold_n = 1'b0; tick();
        read_word(w); chk("R4 capture", 32'(w), 32'hC0DE);
        chk("R6 ok at capture", 32'(data_ok), 32'h0);
        for (int k = 1; k <= S + 2; k++) begin
            cnt_in = 16'(k * 977); cnt_busy = k[0];
            tick();
            read_word(w);
            chk("R4 frozen", 32'(w), 32'hC0DE);
            chk($sformatf("R6 ok edge %0d", k), 32'(data_ok), 32'(k >= S));
        end

        // R12: release resumes tracking
        cnt_busy = 1'b0; cnt_in = 16'h0F0F; hold_n = 1'b1; tick();
        read_word(w); chk("R12 track", 32'(w), 32'h0F0F);
        chk("R12 ok low", 32'(data_ok), 32'h0);

        // R5: freeze requested during busy
        cnt_busy = 1'b1; cnt_in = 16'h1111; hold_n = 1'b0; tick();
        read_word(w); chk("R5 pending", 32'(w), 32'h0F0F);
        chk("R5 ok low", 32'(data_ok), 32'h0);
        cnt_in = 16'h2222; tick();
        read_word(w); chk("R5 pending2", 32'(w), 32'h0F0F);
        cnt_busy = 1'b0; cnt_in = 16'h3333; tick();
        read_word(w); chk("R5 completed", 32'(w), 32'h3333);
        for (int k = 1; k <= S; k++) begin
            cnt_in = 16'h4444 + 16'(k); tick();
            if (k == S - 1) chk("R6 ok early", 32'(data_ok), 32'h0);
        end
        read_word(w); chk("R5 held", 32'(w), 32'h3333);
        chk("R6 ok late", 32'(data_ok), 32'h1);
        hold_n = 1'b1;

        // R7..R10: every pin mode with several words
        for (int p = 0; p < 6; p++) begin
            cnt_in = pats[p]; tick();
            for (int m = 0; m < 8; m++) begin
                logic [15:0] ed, eo;
                oe_n = m[0]; wide_mode = m[1]; hi_byte_sel = m[2];
                #1;
                if (m[0]) begin
                    ed = 16'h0; eo = 16'h0;
                    chk("R7 data", 32'(bus_d), 32'(ed));
                    chk("R7 oe", 32'(bus_oe), 32'(eo));
                end else if (m[1]) begin
                    ed = pats[p]; eo = 16'hFFFF;
                    chk("R10 data", 32'(bus_d), 32'(ed));
                    chk("R10 oe", 32'(bus_oe), 32'(eo));
                end else begin
                    ed = {8'h00, (m[2] ? pats[p][15:8] : pats[p][7:0])};
                    chk("R8 data", 32'(bus_d[7:0]), 32'(ed[7:0]));
                    chk("R8 oe", 32'(bus_oe[7:0]), 32'hFF);
                    chk("R9 data", 32'(bus_d[15:8]), 32'h0);
                    chk("R9 oe", 32'(bus_oe[15:8]), 32'h0);
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule